// File: doc/BRIEF.md
# Escalating Watchdog Timer with Write Lock

This block is a watchdog peripheral that sits on a simple 32-bit register bus. The bus uses word-aligned addresses in a 4 KB window. A down-counter starts from a programmable reload value. It decrements by one on every cycle in which the `tick` strobe is high, provided the watchdog is enabled. When the count runs out the first time, the block raises an interrupt and starts the count again. If software has not serviced that interrupt by the next run-out, the block halts the counter and latches an expiry flag. It also drives a system reset output when reset escalation is enabled.

All configuration writes are protected by a lock. Writes to the reload value, to the control word and to the interrupt-clear location are accepted only after a 32-bit key has been written to the lock location. Eight read-only identification words let software recognise the block.

Software sets a reload value, then enables the block. It services each interrupt by writing the clear location, which also restarts the count. A system that stops servicing the interrupt is brought down by the reset output.

Top module: `wdog_escalate`

## Requirements
- R1: After reset, the reload value (offset 0x000) and the current count (0x004) read 0xFFFFFFFF. Control (0x008), raw status (0x010) and masked status (0x014) read 0. The lock location (0xC00) reads 1, meaning locked. The outputs `irq`, `sys_rst` and `expired` are low.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks the block, and 0xC00 then reads 0. Writing any other value to 0xC00 locks the block again, and 0xC00 then reads 1.
- R3: While the block is locked, writes to 0x000, 0x008 and 0x00C have no effect.
- R4: An accepted write to 0x000 sets the reload value, and the count takes the written value on the same clock edge.
- R5: Control bit 0 enables counting. The count holds while bit 0 is clear or while `tick` is low.
- R6: A time-out occurs on the (reload+1)-th enabled tick. On a time-out with raw status clear, bit 0 of 0x010 becomes 1 and the count reloads.
- R7: Masked status (bit 0 of 0x014) equals raw status AND control bit 0, and `irq` equals masked status.
- R8: An accepted write of any value to 0x00C clears raw status and reloads the count from the reload value.
- R9: On a time-out with raw status already set, `expired` goes high and stays high, and the count freezes. `sys_rst` is high exactly when `expired` is high and control bit 1 is set.
- R10: Words at 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x05, 0x18, 0x14 and 0x00. Words at 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1. Each value sits in bits 7:0 and the upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Watchdog clock enable, one count per high cycle |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | First-stage interrupt |
| sys_rst | output | 1 | Second-stage system reset request |
| expired | output | 1 | Second-stage time-out flag, sticky until reset |

## Verification
The bench counts ticks to the exact edge of each time-out. A counter that is off by one, such as one that fires on reaching zero instead of on the tick after, would raise `irq` one cycle early and fail the interval check. The bench attempts writes to reload, control and clear while the block is locked, and reads the state back to show it is unchanged. A design with a leaky lock would show the new value. The bench also locks the block again with a wrong key. A design that treats any write to the lock location as an unlock would then accept the next write.

The bench drives the second-stage time-out both with and without the reset-enable bit. This catches a reset output that ignores control bit 1, an expiry that fires one stage early, and a counter that keeps running after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam logic [11:0] OFS_RELOAD = 12'h000;
   localparam logic [11:0] OFS_COUNT  = 12'h004;
   localparam logic [11:0] OFS_CTRL   = 12'h008;
   localparam logic [11:0] OFS_CLEAR  = 12'h00C;
   localparam logic [11:0] OFS_RAW    = 12'h010;
   localparam logic [11:0] OFS_MASKED = 12'h014;
   localparam logic [11:0] OFS_LOCK   = 12'hC00;
   localparam logic [11:0] OFS_ID     = 12'hFE0;
   localparam int unsigned ID_WORDS   = 8;

   // Fixed identification bytes, index 0..7 maps to ascending word addresses
   function automatic logic [7:0] id_byte(input int unsigned idx);
      case (idx)
         0: return 8'h05;
         1: return 8'h18;
         2: return 8'h14;
         3: return 8'h00;
         4: return 8'h0D;
         5: return 8'hF0;
         6: return 8'h05;
         default: return 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
   parameter int unsigned DW  = 32,
   parameter int unsigned AW  = 12,
   parameter logic [31:0] KEY = 32'h1ACCE551
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] reload,
   output logic          ctrl_en,
   output logic          ctrl_rst,
   output logic          unlocked,
   output logic          load_pulse,
   output logic          clear_pulse
);
   import wdog_pkg::*;

   logic wr_any;
   logic wr_ok;

   assign wr_any      = sel && wr;
   assign wr_ok       = wr_any && unlocked;
   assign load_pulse  = wr_ok && (addr == AW'(OFS_RELOAD));
   assign clear_pulse = wr_ok && (addr == AW'(OFS_CLEAR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload   <= '1;
         ctrl_en  <= 1'b0;
         ctrl_rst <= 1'b0;
         unlocked <= 1'b0;
      end else begin
         if (wr_any && addr == AW'(OFS_LOCK))
            unlocked <= (wdata == DW'(KEY));
         if (load_pulse)
            reload <= wdata;
         if (wr_ok && addr == AW'(OFS_CTRL)) begin
            ctrl_en  <= wdata[0];
            ctrl_rst <= wdata[1];
         end
      end
   end

   // R3: locked writes leave reload and control untouched
   a_r3_locked_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && !unlocked && addr == AW'(OFS_RELOAD)) |=> $stable(reload));
   a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && !unlocked && addr == AW'(OFS_CTRL)) |=> ($stable(ctrl_en) && $stable(ctrl_rst)));
   a_r2_unlock_only_via_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_any && addr == AW'(OFS_LOCK)));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  logic [DW-1:0] reload,
   input  logic          load_pulse,
   input  logic [DW-1:0] load_val,
   input  logic          clear_pulse,
   output logic [DW-1:0] count,
   output logic          raw,
   output logic          expired
);
   logic step;
   logic at_zero;

   assign step    = en && tick && !expired;
   assign at_zero = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '1;
         raw     <= 1'b0;
         expired <= 1'b0;
      end else if (load_pulse) begin
         count <= load_val;
      end else if (clear_pulse) begin
         raw   <= 1'b0;
         count <= reload;
      end else if (step) begin
         if (!at_zero) begin
            count <= count - 1'b1;
         end else if (!raw) begin
            raw   <= 1'b1;
            count <= reload;
         end else begin
            expired <= 1'b1;
         end
      end
   end

   // R5: no enable or no tick, no change
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(en && tick) && !load_pulse && !clear_pulse) |=> ($stable(count) && $stable(raw)));
   // R6: raw status only rises on an enabled tick at zero count
   a_r6_raw_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw) |-> $past(en && tick && count == '0));
   // R9: escalation needs a pending first stage, and a frozen counter after
   a_r9_escalate_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> $past(raw));
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load_pulse && !clear_pulse) |=> $stable(count));
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> expired);
endmodule

// File: rtl/wdog_idrom.sv
module wdog_idrom #(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 12
) (
   input  logic [AW-1:0] addr,
   output logic          hit,
   output logic [DW-1:0] data
);
   import wdog_pkg::*;

   logic [ID_WORDS-1:0] sel_vec;
   logic [DW-1:0]       word [ID_WORDS];

   for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
      assign sel_vec[g] = (addr == AW'(OFS_ID + 12'(4 * g)));
      assign word[g]    = sel_vec[g] ? DW'(id_byte(g)) : '0;
   end

   always_comb begin
      data = '0;
      for (int i = 0; i < ID_WORDS; i++) data = data | word[i];
   end

   assign hit = |sel_vec;

   // R10: at most one identification word decodes at a time
   always_comb a_r10_one_hot: assert ($onehot0(sel_vec));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
   parameter int unsigned DW      = 32,
   parameter int unsigned AW      = 12,
   parameter logic [31:0] KEY     = 32'h1ACCE551,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq,
   output logic          sys_rst,
   output logic          expired
);
   import wdog_pkg::*;

   if (DW < 32) begin : g_bad_dw
      initial $error("wdog_escalate: DW must be at least 32");
   end
   if (AW < 12) begin : g_bad_aw
      initial $error("wdog_escalate: AW must cover a 4 KB window");
   end

   logic [DW-1:0] reload;
   logic [DW-1:0] count;
   logic          ctrl_en;
   logic          ctrl_rst;
   logic          unlocked;
   logic          load_pulse;
   logic          clear_pulse;
   logic          raw;
   logic          masked;
   logic          id_hit;
   logic [DW-1:0] id_data;

   wdog_regs #(.DW(DW), .AW(AW), .KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .reload(reload),
      .ctrl_en(ctrl_en), .ctrl_rst(ctrl_rst), .unlocked(unlocked),
      .load_pulse(load_pulse), .clear_pulse(clear_pulse)
   );

   wdog_counter #(.DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_en),
      .reload(reload), .load_pulse(load_pulse), .load_val(bus_wdata),
      .clear_pulse(clear_pulse), .count(count), .raw(raw), .expired(expired)
   );

   wdog_idrom #(.DW(DW), .AW(AW)) u_id (
      .addr(bus_addr), .hit(id_hit), .data(id_data)
   );

   assign masked  = raw && ctrl_en;
   assign sys_rst = expired && ctrl_rst;

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= masked;
      end
   end else begin : g_irq_comb
      assign irq = masked;
   end

   always_comb begin
      bus_rdata = '0;
      if (id_hit) begin
         bus_rdata = id_data;
      end else begin
         case (bus_addr)
            AW'(OFS_RELOAD): bus_rdata = reload;
            AW'(OFS_COUNT):  bus_rdata = count;
            AW'(OFS_CTRL):   bus_rdata = DW'({ctrl_rst, ctrl_en});
            AW'(OFS_RAW):    bus_rdata = DW'(raw);
            AW'(OFS_MASKED): bus_rdata = DW'(masked);
            AW'(OFS_LOCK):   bus_rdata = DW'(!unlocked);
            default:         bus_rdata = '0;
         endcase
      end
   end

   // R9: reset output needs both expiry and its enable
   a_r9_rst_gate: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> (expired && ctrl_rst));
   // R8: an accepted clear drops the raw status on the next edge
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_pulse && !load_pulse) |=> !raw);
endmodule

// File: tb/wdog_escalate_tb.sv
module wdog_escalate_tb;
   localparam int CLK_NS = 10;
   localparam logic [31:0] KEY = 32'h1ACCE551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sys_rst, expired;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   wdog_escalate u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sys_rst(sys_rst), .expired(expired)
   );

   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0;
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic bwr(input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step(1);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(12'h000, v); chk("R1 reload", v, 32'hFFFFFFFF);
      rd(12'h004, v); chk("R1 count", v, 32'hFFFFFFFF);
      rd(12'h008, v); chk("R1 ctrl", v, 0);
      rd(12'h010, v); chk("R1 raw", v, 0);
      rd(12'h014, v); chk("R1 masked", v, 0);
      rd(12'hC00, v); chk("R1 lock", v, 1);
      chk("R1 outputs", {29'b0, irq, sys_rst, expired}, 0);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      do_reset();
      bwr(12'h000, 32'd5);
      rd(12'h000, v); chk("R3 locked reload", v, 32'hFFFFFFFF);
      bwr(12'h008, 32'd3);
      rd(12'h008, v); chk("R3 locked ctrl", v, 0);
      bwr(12'hC00, KEY);
      rd(12'hC00, v); chk("R2 unlocked reads 0", v, 0);
      bwr(12'h000, 32'd5);
      rd(12'h000, v); chk("R4 reload written", v, 5);
      rd(12'h004, v); chk("R4 count restarted", v, 5);
      bwr(12'hC00, 32'h1ACCE550);
      rd(12'hC00, v); chk("R2 wrong key relocks", v, 1);
      bwr(12'h000, 32'd9);
      rd(12'h000, v); chk("R2 relocked reload", v, 5);
   endtask

   task automatic t_ids();
      logic [31:0] v;
      logic [7:0] exp [8] = '{8'h05, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int i = 0; i < 8; i++) begin
         rd(12'hFE0 + 12'(4 * i), v);
         chk($sformatf("R10 id word %0d", i), v, {24'b0, exp[i]});
      end
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      do_reset();
      bwr(12'hC00, KEY);
      bwr(12'h000, 32'd3);
      bwr(12'h008, 32'd1);
      step(5);
      rd(12'h004, v); chk("R5 no tick holds", v, 3);
      tick = 1'b1;
      step(3);
      rd(12'h004, v); chk("R6 count at zero", v, 0);
      chk("R6 no early irq", irq, 0);
      step(1);
      tick = 1'b0;
      chk("R6 irq after reload+1", irq, 1);
      rd(12'h010, v); chk("R6 raw set", v, 1);
      rd(12'h004, v); chk("R6 reloaded", v, 3);
      rd(12'h014, v); chk("R7 masked on", v, 1);
      bwr(12'h008, 32'd0);
      chk("R7 irq masked", irq, 0);
      rd(12'h014, v); chk("R7 masked off", v, 0);
      rd(12'h010, v); chk("R7 raw kept", v, 1);
      tick = 1'b1;
      step(6);
      tick = 1'b0;
      rd(12'h004, v); chk("R5 disabled holds", v, 3);
      bwr(12'hC00, 32'h0);
      bwr(12'h00C, 32'h0);
      rd(12'h010, v); chk("R3 locked clear", v, 1);
      bwr(12'hC00, KEY);
      bwr(12'h000, 32'd7);
      bwr(12'h00C, 32'h0);
      rd(12'h010, v); chk("R8 raw cleared", v, 0);
      rd(12'h004, v); chk("R8 count reloaded", v, 7);
   endtask

   task automatic t_escalate(input logic [31:0] ctl);
      logic [31:0] v;
      do_reset();
      bwr(12'hC00, KEY);
      bwr(12'h000, 32'd2);
      bwr(12'h008, ctl);
      tick = 1'b1;
      step(3);
      chk("R6 first stage irq", irq, 1);
      step(2);
      chk("R9 no early expiry", expired, 0);
      step(1);
      chk("R9 expired", expired, 1);
      chk("R9 reset gated by ctrl bit 1", sys_rst, ctl[1]);
      step(4);
      tick = 1'b0;
      rd(12'h004, v); chk("R9 counter frozen", v, 0);
      chk("R9 expiry sticky", expired, 1);
   endtask

   initial begin
      t_reset();
      t_lock();
      t_ids();
      t_timeout();
      t_escalate(32'd3);
      t_escalate(32'd1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule